// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the programming front end of an eight-line priority interrupt controller. It owns a byte-wide register port with a single address bit. Writes carry either the words of a short initialization sequence or operational commands. The block turns them into the configuration that the priority resolver uses: the line mask, the vector base, the nested and automatic end-of-interrupt mode bits, the special-mask flag and the rotation base. It also turns them into one-cycle strobes that clear in-service and request bits held in the resolver.

Reads are combinational. Address 1 returns the mask. Address 0 returns either the request register or the in-service register supplied by the resolver, depending on a read-select flag. When a poll has been armed, the next read instead returns the resolver's winning line, or 7 when no line is pending, and retires that line. The decoder never ranks requests itself. For a nonspecific end of interrupt it only picks the most important in-service line under the current rotation base.

Top module: `pic_cmd_dec`

## Requirements
- R1: A write at address 0 with bit 4 set starts initialization. On the next cycle the mask, rotation base, special-mask flag and read-select flag are 0, and clr_req_o equals the inverse of level_i for that one cycle, which drops edge-sensitive requests. When bit 0 of that word is 0, the nested and auto end-of-interrupt flags are also cleared; otherwise they keep their values.
- R2: The first address-1 write after an initialization word sets vec_base_o to the data with its three low bits forced to 0.
- R3: The second address-1 write goes to the fourth-word phase when bit 0 of the initialization word was 1, and to normal operation otherwise. In the fourth-word phase an address-1 write sets nested_o from bit 4 and auto_eoi_o from bit 1, then returns to normal operation.
- R4: In normal operation an address-1 write loads the mask with the data byte.
- R5: A write at address 0 with bit 3 set and bit 4 clear is a read/poll command. Bit 1 set loads the read-select flag from bit 0. Bit 6 set loads the special-mask flag from bit 5. Bit 2 set arms poll. A flag whose enable bit is clear keeps its value.
- R6: With poll not armed, rdata_o shows the mask at address 1, and at address 0 shows isr_i when read-select is 1 or req_i when it is 0, in the same cycle.
- R7: Any other address-0 write takes bits 7:5 as a command. Commands 0 and 4 set rot_aeoi_o from bit 7.
- R8: Command 1 clears, through clr_isr_o, the in-service line of highest priority. Priority runs from the rotation base upward and wraps. With no line in service it does nothing.
- R9: Command 5 acts as command 1 and also sets the rotation base to the cleared line plus 1, modulo 8.
- R10: Command 3 clears in-service line data[2:0]. Command 7 does the same and sets the rotation base to data[2:0] plus 1, modulo 8.
- R11: Command 6 sets the rotation base to data[2:0] plus 1, modulo 8. Command 2 changes nothing.
- R12: With poll armed, rdata_o is the poll line index when poll_hit_i is 1, else 7. Any read then disarms poll. A read with a hit pulses that line on both clr_isr_o and clr_req_o on the next cycle.
- R13: clr_isr_o and clr_req_o are registered strobes that stay high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe, one cycle per byte |
| rd_en_i | input | 1 | Read strobe, one cycle per byte |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| req_i | input | 8 | Request register from resolver |
| isr_i | input | 8 | In-service register from resolver |
| level_i | input | 8 | Per-line level-sensitive flags |
| poll_hit_i | input | 1 | Resolver has a winning line |
| poll_line_i | input | 3 | Index of that winning line |
| mask_o | output | 8 | Line mask |
| vec_base_o | output | 8 | Vector base, low three bits 0 |
| nested_o | output | 1 | Special nested mode |
| auto_eoi_o | output | 1 | Automatic end of interrupt |
| rot_aeoi_o | output | 1 | Rotate on automatic end of interrupt |
| special_mask_o | output | 1 | Special mask mode |
| rot_base_o | output | 3 | Rotation base (highest-priority line) |
| clr_isr_o | output | 8 | One-cycle in-service clear strobes |
| clr_req_o | output | 8 | One-cycle request clear strobes |

## Verification
Most internal state of this decoder shows up at the ports only later. A sequencer stuck in the wrong phase appears when the next address-1 write lands in the vector base, the mode bits or the mask, or fails to land in any of them. A wrong rotation base appears only at the next nonspecific end of interrupt, which then clears the wrong line on the cycle after the command. A read-select or poll flag that is set wrongly changes rdata_o in the same cycle as the next read. A poll that stays armed changes the read that follows it. The tests therefore follow each command with the write or read that exposes it.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
    parameter int PIC_LINES = 8;
    localparam int IDX_W = $clog2(PIC_LINES);

    // address-0 word classification bits
    localparam int BIT_INIT = 4;
    localparam int BIT_RDCMD = 3;

    localparam logic [2:0] CMD_ROT_OFF  = 3'd0;
    localparam logic [2:0] CMD_NS_EOI   = 3'd1;
    localparam logic [2:0] CMD_NOP      = 3'd2;
    localparam logic [2:0] CMD_SP_EOI   = 3'd3;
    localparam logic [2:0] CMD_ROT_ON   = 3'd4;
    localparam logic [2:0] CMD_NS_ROT   = 3'd5;
    localparam logic [2:0] CMD_SET_PRI  = 3'd6;
    localparam logic [2:0] CMD_SP_ROT   = 3'd7;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_BASE = 2'd1,
        PH_W3   = 2'd2,
        PH_W4   = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e               phase;
        logic [PIC_LINES-1:0] mask;
        logic [PIC_LINES-1:0] vbase;
        logic                 need_w4;
        logic                 nested;
        logic                 aeoi;
        logic                 rot_aeoi;
        logic                 smask;
        logic                 rsel;
        logic                 poll;
        logic [IDX_W-1:0]     rot_base;
        logic [PIC_LINES-1:0] clr_isr;
        logic [PIC_LINES-1:0] clr_req;
    } dec_state_t;
endpackage

// File: rtl/pic_cmd_isr_pick.sv
module pic_cmd_isr_pick
    import pic_cmd_pkg::*;
(
    input  logic [PIC_LINES-1:0] set_i,
    input  logic [IDX_W-1:0]     base_i,
    output logic                 hit_o,
    output logic [IDX_W-1:0]     idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        // scan from lowest priority to highest so the last hit wins
        for (int k = PIC_LINES - 1; k >= 0; k--) begin
            logic [IDX_W-1:0] cand;
            cand = base_i + IDX_W'(k);
            if (set_i[cand]) begin
                hit_o = 1'b1;
                idx_o = cand;
            end
        end
    end
endmodule

// File: rtl/pic_cmd_rdmux.sv
module pic_cmd_rdmux
    import pic_cmd_pkg::*;
(
    input  logic                 poll_i,
    input  logic                 poll_hit_i,
    input  logic [IDX_W-1:0]     poll_line_i,
    input  logic                 addr_i,
    input  logic                 rsel_i,
    input  logic [PIC_LINES-1:0] mask_i,
    input  logic [PIC_LINES-1:0] req_i,
    input  logic [PIC_LINES-1:0] isr_i,
    output logic [PIC_LINES-1:0] rdata_o
);
    localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(PIC_LINES - 1);

    always_comb begin
        if (poll_i) begin
            rdata_o = PIC_LINES'(poll_hit_i ? poll_line_i : NONE_IDX);
        end else if (addr_i) begin
            rdata_o = mask_i;
        end else begin
            rdata_o = rsel_i ? isr_i : req_i;
        end
    end
endmodule

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
    import pic_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic                 addr_i,
    input  logic [PIC_LINES-1:0] wdata_i,
    output logic [PIC_LINES-1:0] rdata_o,
    input  logic [PIC_LINES-1:0] req_i,
    input  logic [PIC_LINES-1:0] isr_i,
    input  logic [PIC_LINES-1:0] level_i,
    input  logic                 poll_hit_i,
    input  logic [IDX_W-1:0]     poll_line_i,
    output logic [PIC_LINES-1:0] mask_o,
    output logic [PIC_LINES-1:0] vec_base_o,
    output logic                 nested_o,
    output logic                 auto_eoi_o,
    output logic                 rot_aeoi_o,
    output logic                 special_mask_o,
    output logic [IDX_W-1:0]     rot_base_o,
    output logic [PIC_LINES-1:0] clr_isr_o,
    output logic [PIC_LINES-1:0] clr_req_o
);
    localparam logic [PIC_LINES-1:0] BASE_KEEP = ~PIC_LINES'((1 << IDX_W) - 1);

    dec_state_t st_q, st_d;

    logic             top_hit;
    logic [IDX_W-1:0] top_idx;

    pic_cmd_isr_pick u_pick (
        .set_i  (isr_i),
        .base_i (st_q.rot_base),
        .hit_o  (top_hit),
        .idx_o  (top_idx)
    );

    pic_cmd_rdmux u_rdmux (
        .poll_i      (st_q.poll),
        .poll_hit_i  (poll_hit_i),
        .poll_line_i (poll_line_i),
        .addr_i      (addr_i),
        .rsel_i      (st_q.rsel),
        .mask_i      (st_q.mask),
        .req_i       (req_i),
        .isr_i       (isr_i),
        .rdata_o     (rdata_o)
    );

    always_comb begin
        logic [IDX_W-1:0] arg;
        arg = wdata_i[IDX_W-1:0];
        st_d = st_q;
        st_d.clr_isr = '0;
        st_d.clr_req = '0;

        // poll read: retire the winner and disarm
        if (rd_en_i && st_q.poll) begin
            st_d.poll = 1'b0;
            if (poll_hit_i) begin
                st_d.clr_isr[poll_line_i] = 1'b1;
                st_d.clr_req[poll_line_i] = 1'b1;
            end
        end

        if (wr_en_i && !addr_i) begin
            if (wdata_i[BIT_INIT]) begin
                st_d.need_w4  = wdata_i[0];
                st_d.mask     = '0;
                st_d.rot_base = '0;
                st_d.smask    = 1'b0;
                st_d.rsel     = 1'b0;
                st_d.phase    = PH_BASE;
                st_d.clr_req  = ~level_i;
                if (!wdata_i[0]) begin
                    st_d.nested = 1'b0;
                    st_d.aeoi   = 1'b0;
                end
            end else if (wdata_i[BIT_RDCMD]) begin
                if (wdata_i[2]) st_d.poll  = 1'b1;
                if (wdata_i[1]) st_d.rsel  = wdata_i[0];
                if (wdata_i[6]) st_d.smask = wdata_i[5];
            end else begin
                unique case (wdata_i[7:5])
                    CMD_ROT_OFF, CMD_ROT_ON: st_d.rot_aeoi = wdata_i[7];
                    CMD_NS_EOI, CMD_NS_ROT: begin
                        if (top_hit) begin
                            st_d.clr_isr[top_idx] = 1'b1;
                            if (wdata_i[7]) st_d.rot_base = top_idx + IDX_W'(1);
                        end
                    end
                    CMD_SP_EOI: st_d.clr_isr[arg] = 1'b1;
                    CMD_SET_PRI: st_d.rot_base = arg + IDX_W'(1);
                    CMD_SP_ROT: begin
                        st_d.clr_isr[arg] = 1'b1;
                        st_d.rot_base     = arg + IDX_W'(1);
                    end
                    CMD_NOP: ;
                    default: ;
                endcase
            end
        end else if (wr_en_i && addr_i) begin
            unique case (st_q.phase)
                PH_RUN:  st_d.mask = wdata_i;
                PH_BASE: begin
                    st_d.vbase = wdata_i & BASE_KEEP;
                    st_d.phase = PH_W3;
                end
                PH_W3:   st_d.phase = st_q.need_w4 ? PH_W4 : PH_RUN;
                PH_W4: begin
                    st_d.nested = wdata_i[4];
                    st_d.aeoi   = wdata_i[1];
                    st_d.phase  = PH_RUN;
                end
                default: st_d.phase = PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o         = st_q.mask;
    assign vec_base_o     = st_q.vbase;
    assign nested_o       = st_q.nested;
    assign auto_eoi_o     = st_q.aeoi;
    assign rot_aeoi_o     = st_q.rot_aeoi;
    assign special_mask_o = st_q.smask;
    assign rot_base_o     = st_q.rot_base;
    assign clr_isr_o      = st_q.clr_isr;
    assign clr_req_o      = st_q.clr_req;
endmodule

// File: rtl/pic_cmd_chk.sv
module pic_cmd_chk
    import pic_cmd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic                 rd_en_i,
    input logic                 addr_i,
    input logic [PIC_LINES-1:0] wdata_i,
    input logic [PIC_LINES-1:0] isr_i,
    input logic [PIC_LINES-1:0] mask_o,
    input logic [IDX_W-1:0]     rot_base_o,
    input logic [PIC_LINES-1:0] clr_isr_o,
    input logic [PIC_LINES-1:0] clr_req_o
);
    p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && wdata_i[4]) |=> (mask_o == '0 && rot_base_o == '0));

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mask_o));

    p_ns_eoi_hits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && wdata_i[7:3] == 5'b00100 && isr_i != '0)
        |=> (clr_isr_o & $past(isr_i)) != '0);

    p_set_pri_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && wdata_i[7:3] == 5'b11000)
        |=> rot_base_o == $past(wdata_i[IDX_W-1:0]) + IDX_W'(1));

    p_clr_req_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req_o != '0) |-> $past(rd_en_i || (wr_en_i && !addr_i && wdata_i[4])));

    p_single_eoi_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_isr_o));
endmodule

bind pic_cmd_dec pic_cmd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .isr_i      (isr_i),
    .mask_o     (mask_o),
    .rot_base_o (rot_base_o),
    .clr_isr_o  (clr_isr_o),
    .clr_req_o  (clr_req_o)
);

// File: tb/pic_cmd_dec_tb.sv
`timescale 1ns/1ps
module pic_cmd_dec_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, req = '0, isr = '0, level = '0;
    logic       poll_hit = 1'b0;
    logic [2:0] poll_line = '0;
    logic [7:0] rdata, mask, vbase, clr_isr, clr_req;
    logic       nested, aeoi, rot_aeoi, smask;
    logic [2:0] rot_base;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pic_cmd_dec u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .req_i(req),
        .isr_i(isr), .level_i(level), .poll_hit_i(poll_hit),
        .poll_line_i(poll_line), .mask_o(mask), .vec_base_o(vbase),
        .nested_o(nested), .auto_eoi_o(aeoi), .rot_aeoi_o(rot_aeoi),
        .special_mask_o(smask), .rot_base_o(rot_base),
        .clr_isr_o(clr_isr), .clr_req_o(clr_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive for one cycle; on return the registered effects are visible
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 reset mask", mask, 8'h00);
        chk("R11 reset rot base", {5'd0, rot_base}, 8'h00);
        wr(1'b1, 8'h5A);
        chk("R4 mask write after reset", mask, 8'h5A);
        rd(1'b1, d);
        chk("R6 mask read", d, 8'h5A);
    endtask

    task automatic t_init_four();
        level = 8'hA0;
        wr(1'b0, 8'h11);
        chk("R1 mask cleared", mask, 8'h00);
        chk("R1 edge requests dropped", clr_req, 8'h5F);
        wr(1'b1, 8'h47);
        chk("R2 vector base", vbase, 8'h40);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h12);
        chk("R3 nested set", {7'd0, nested}, 8'h01);
        chk("R3 auto eoi set", {7'd0, aeoi}, 8'h01);
        chk("R3 mask untouched by fourth word", mask, 8'h00);
        wr(1'b1, 8'h3C);
        chk("R4 mask after init", mask, 8'h3C);
    endtask

    task automatic t_init_three();
        wr(1'b0, 8'h6B);   // read select = isr, special mask on
        wr(1'b0, 8'hC2);   // rotation base 3
        chk("R5 special mask set", {7'd0, smask}, 8'h01);
        level = 8'hFF;
        wr(1'b0, 8'h10);
        chk("R1 nested cleared", {7'd0, nested}, 8'h00);
        chk("R1 auto eoi cleared", {7'd0, aeoi}, 8'h00);
        chk("R1 special mask cleared", {7'd0, smask}, 8'h00);
        chk("R1 rot base cleared", {5'd0, rot_base}, 8'h00);
        chk("R1 level requests kept", clr_req, 8'h00);
        wr(1'b1, 8'h2F);
        chk("R2 vector base low bits", vbase, 8'h28);
        wr(1'b1, 8'hFF);
        wr(1'b1, 8'h81);
        chk("R3 no fourth word, mask loads", mask, 8'h81);
        chk("R3 nested untouched", {7'd0, nested}, 8'h00);
    endtask

    task automatic t_readcmd();
        logic [7:0] d;
        req = 8'h96; isr = 8'h24;
        rd(1'b0, d);
        chk("R1 read select cleared by init", d, 8'h96);
        wr(1'b0, 8'h0B);
        rd(1'b0, d);
        chk("R5 R6 isr read", d, 8'h24);
        wr(1'b0, 8'h08);
        rd(1'b0, d);
        chk("R5 read select held", d, 8'h24);
        wr(1'b0, 8'h0A);
        rd(1'b0, d);
        chk("R6 request read", d, 8'h96);
        wr(1'b0, 8'h68);
        chk("R5 special mask on", {7'd0, smask}, 8'h01);
        wr(1'b0, 8'h28);
        chk("R5 special mask held", {7'd0, smask}, 8'h01);
        wr(1'b0, 8'h48);
        chk("R5 special mask off", {7'd0, smask}, 8'h00);
    endtask

    task automatic t_rot_aeoi();
        wr(1'b0, 8'h80);
        chk("R7 rotate on aeoi", {7'd0, rot_aeoi}, 8'h01);
        wr(1'b0, 8'h00);
        chk("R7 rotate off", {7'd0, rot_aeoi}, 8'h00);
    endtask

    task automatic t_eoi();
        isr = 8'h28;
        wr(1'b0, 8'h20);
        chk("R8 nonspecific base 0", clr_isr, 8'h08);
        @(negedge clk); #1;
        chk("R13 strobe one cycle", clr_isr, 8'h00);
        wr(1'b0, 8'hC4);
        chk("R11 set priority", {5'd0, rot_base}, 8'h05);
        wr(1'b0, 8'h20);
        chk("R8 nonspecific rotated", clr_isr, 8'h20);
        isr = 8'h09;
        wr(1'b0, 8'hA0);
        chk("R9 wrap pick", clr_isr, 8'h01);
        chk("R9 rot base line+1", {5'd0, rot_base}, 8'h01);
        isr = 8'h00;
        wr(1'b0, 8'hA0);
        chk("R8 empty no clear", clr_isr, 8'h00);
        chk("R9 empty rot held", {5'd0, rot_base}, 8'h01);
        wr(1'b0, 8'h63);
        chk("R10 specific eoi", clr_isr, 8'h08);
        wr(1'b0, 8'hE6);
        chk("R10 specific rotate clear", clr_isr, 8'h40);
        chk("R10 specific rotate base", {5'd0, rot_base}, 8'h07);
        wr(1'b0, 8'h45);
        chk("R11 nop strobe", clr_isr, 8'h00);
        chk("R11 nop rot", {5'd0, rot_base}, 8'h07);
        wr(1'b0, 8'hC7);
        chk("R11 set priority wraps", {5'd0, rot_base}, 8'h00);
    endtask

    task automatic t_poll();
        logic [7:0] d;
        wr(1'b0, 8'h0C);
        poll_hit = 1'b1; poll_line = 3'd5;
        rd(1'b1, d);
        chk("R12 poll line", d, 8'h05);
        chk("R12 poll clears isr", clr_isr, 8'h20);
        chk("R12 poll clears req", clr_req, 8'h20);
        rd(1'b1, d);
        chk("R12 poll disarmed", d, 8'h81);
        chk("R13 poll strobe ended", clr_req, 8'h00);
        wr(1'b0, 8'h0C);
        poll_hit = 1'b0;
        rd(1'b0, d);
        chk("R12 poll none", d, 8'h07);
        chk("R12 poll none no clear", clr_isr, 8'h00);
        poll_hit = 1'b1;
        rd(1'b1, d);
        chk("R12 poll disarmed after miss", d, 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_init_four();
        t_init_three();
        t_readcmd();
        t_rot_aeoi();
        t_eoi();
        t_poll();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule